// File: doc/BRIEF.md
# Bus Message Descriptor Handler

This block moves one bus message's control/status descriptor between shared memory and a transfer engine. A sequencer gives it the descriptor's start address with a one-cycle start strobe. The block first checks the address alignment. It then reads the control word, the time-to-next-message value, the data block pointer and the command word. It offers these to the transfer engine and holds them there until the engine reports that the message is complete. It then writes the engine's status, loopback and block status results back into the descriptor, together with a time tag sampled from a free-running timer.

A bit in the control word marks the message as a transfer from one remote terminal to another. Such a message uses a 16-word descriptor. The block also reads the second command word at offset 8 and writes the second status word at offset 9, and it leaves offsets 10 to 15 alone. A normal descriptor is 8 words long and must start on a multiple of 8. A terminal-to-terminal descriptor must start on a multiple of 16. A start address that breaks its rule ends the message with an error pulse, and nothing is written to memory. Memory is reached over a request/acknowledge port, one word per cycle at most.

Top module: `msg_desc_engine`

## Requirements
- R1: After reset, busy, done, align_err, mem_req and xfer_req are all low.
- R2: start is taken only while busy is low. A start pulse that arrives while busy is high causes no memory access, no extra done pulse and no change to the message in progress.
- R3: When the accepted start address has a nonzero value in bits 2..0, the block pulses done and align_err together in the cycle after start. It makes no memory access.
- R4: A normal message reads offsets 0, 1, 2 and 3 (control, time-to-next, data pointer, command) in ascending order. Each request holds mem_addr and mem_we steady until mem_ack.
- R5: When bit RTRT_BIT (default 0) of the control word is set, the message uses the 16-word layout. After offset 3 it also reads offset 8 (second command), and desc_rtrt is high.
- R6: When the control word marks a 16-word message and address bit 3 is set, the block reads only offset 0. It then pulses done with align_err and writes nothing.
- R7: After the reads, xfer_req stays high with the read words on the desc_* outputs until xfer_done. No memory access happens while xfer_req is high.
- R8: After xfer_done the block writes offsets 4, 5, 6 and 7 in that order (status, loopback, block status, time tag), then offset 9 (second status) for a 16-word message. No other descriptor word changes.
- R9: The time tag is the number of rising clock edges since reset release, taken at the edge on which xfer_done is sampled high.
- R10: After the last write is acknowledged, done pulses for exactly one cycle with align_err low. busy is high from the start until done, and it is low in the cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to process a descriptor |
| start_addr | input | AW | Descriptor start address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access completes on this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| xfer_req | output | 1 | Descriptor is ready for the transfer engine |
| desc_rtrt | output | 1 | Message uses the 16-word layout |
| desc_ctrl | output | DW | Control word |
| desc_ttnm | output | DW | Time-to-next-message value |
| desc_dptr | output | DW | Data block pointer |
| desc_cmd | output | DW | Command word |
| desc_cmd2 | output | DW | Second command word |
| xfer_done | input | 1 | Transfer finished; result inputs are valid |
| xfer_sts | input | DW | Status word |
| xfer_loop | input | DW | Loopback word |
| xfer_bsts | input | DW | Block status word |
| xfer_sts2 | input | DW | Second status word |
| busy | output | 1 | A message is in progress |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | Alignment abort, valid with done |

## Verification
The assertions assume that the memory only raises mem_ack while mem_req is high. They also assume that xfer_done arrives only while xfer_req is high and lasts one cycle. The bench's memory model derives ack from the sampled mem_req, and its engine model drives xfer_done only after it has seen xfer_req. The stimulus sweeps every start offset from 0 to 47 for both layouts, with a stall-free memory and with a pseudo-random stalling memory. Two further runs pulse start in the middle of a message.

// File: rtl/msg_desc_engine.sv
module msg_desc_engine #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int RTRT_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          xfer_req,
  output logic          desc_rtrt,
  output logic [DW-1:0] desc_ctrl,
  output logic [DW-1:0] desc_ttnm,
  output logic [DW-1:0] desc_dptr,
  output logic [DW-1:0] desc_cmd,
  output logic [DW-1:0] desc_cmd2,
  input  logic          xfer_done,
  input  logic [DW-1:0] xfer_sts,
  input  logic [DW-1:0] xfer_loop,
  input  logic [DW-1:0] xfer_bsts,
  input  logic [DW-1:0] xfer_sts2,
  output logic          busy,
  output logic          done,
  output logic          align_err
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_XF, S_WR} state_t;

  state_t        state;
  logic [AW-1:0] base;
  logic [2:0]    idx;
  logic [DW-1:0] sts, loopw, bsts, sts2, tag, tmr;
  logic [3:0]    off;
  logic [2:0]    last;

  assign busy      = state != S_IDLE;
  assign mem_req   = state == S_RD || state == S_WR;
  assign mem_we    = state == S_WR;
  assign xfer_req  = state == S_XF;
  assign desc_rtrt = desc_ctrl[RTRT_BIT];
  assign last      = desc_rtrt ? 3'd4 : 3'd3;

  always_comb begin
    if (state == S_WR) off = idx[2] ? 4'd9 : {2'b01, idx[1:0]};
    else               off = idx[2] ? 4'd8 : {2'b00, idx[1:0]};
  end

  assign mem_addr = base + {{(AW-4){1'b0}}, off};

  always_comb begin
    case (idx)
      3'd0:    mem_wdata = sts;
      3'd1:    mem_wdata = loopw;
      3'd2:    mem_wdata = bsts;
      3'd3:    mem_wdata = tag;
      default: mem_wdata = sts2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      base      <= '0;
      idx       <= '0;
      tmr       <= '0;
      done      <= 1'b0;
      align_err <= 1'b0;
      desc_ctrl <= '0;
      desc_ttnm <= '0;
      desc_dptr <= '0;
      desc_cmd  <= '0;
      desc_cmd2 <= '0;
      sts       <= '0;
      loopw     <= '0;
      bsts      <= '0;
      sts2      <= '0;
      tag       <= '0;
    end else begin
      tmr       <= tmr + 1'b1;
      done      <= 1'b0;
      align_err <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (start_addr[2:0] != 3'd0) begin
            done      <= 1'b1;
            align_err <= 1'b1;
          end else begin
            base  <= start_addr;
            idx   <= '0;
            state <= S_RD;
          end
        end
        S_RD: if (mem_ack) begin
          case (idx)
            3'd0:    desc_ctrl <= mem_rdata;
            3'd1:    desc_ttnm <= mem_rdata;
            3'd2:    desc_dptr <= mem_rdata;
            3'd3:    desc_cmd  <= mem_rdata;
            default: desc_cmd2 <= mem_rdata;
          endcase
          if (idx == 3'd0 && mem_rdata[RTRT_BIT] && base[3]) begin
            state     <= S_IDLE;
            done      <= 1'b1;
            align_err <= 1'b1;
          end else if (idx != 3'd0 && idx == last) begin
            state <= S_XF;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_XF: if (xfer_done) begin
          sts   <= xfer_sts;
          loopw <= xfer_loop;
          bsts  <= xfer_bsts;
          sts2  <= xfer_sts2;
          tag   <= tmr;
          idx   <= '0;
          state <= S_WR;
        end
        default: if (mem_ack) begin
          if (idx == last) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/msg_desc_engine_chk.sv
module msg_desc_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    start_lo,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] base,
  input logic          xfer_req,
  input logic          busy,
  input logic          done,
  input logic          align_err
);

  logic [AW-1:0] rel;
  assign rel = mem_addr - base;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy && !done && !mem_req) else $error("AST_RESET_QUIET"); // R1
  AST_START_BAD: assert property (@(posedge clk) disable iff (!rst_n) start && !busy && start_lo != 3'd0 |=> done && align_err && !mem_req) else $error("AST_START_BAD"); // R3
  AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n) align_err |-> done) else $error("AST_ERR_DONE"); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)) else $error("AST_REQ_HOLD"); // R4
  AST_XFER_EXCL: assert property (@(posedge clk) disable iff (!rst_n) xfer_req |-> !mem_req) else $error("AST_XFER_EXCL"); // R7
  AST_WR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n) mem_req && mem_we |-> (rel >= AW'(4) && rel <= AW'(7)) || rel == AW'(9)) else $error("AST_WR_OFFSET"); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy) else $error("AST_DONE_IDLE"); // R10

endmodule

bind msg_desc_engine msg_desc_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_lo(start_addr[2:0]),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .base(base), .xfer_req(xfer_req), .busy(busy), .done(done), .align_err(align_err)
);

// File: tb/msg_desc_engine_test.sv
`timescale 1ns/1ps
module msg_desc_engine_test;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic xfer_req, desc_rtrt, xfer_done = 1'b0;
  logic [DW-1:0] desc_ctrl, desc_ttnm, desc_dptr, desc_cmd, desc_cmd2;
  logic [DW-1:0] xfer_sts = '0, xfer_loop = '0, xfer_bsts = '0, xfer_sts2 = '0;
  logic busy, done, align_err;

  msg_desc_engine #(.AW(AW), .DW(DW), .RTRT_BIT(0)) uut (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] pre [256];
  int nlog;
  bit log_we [64];
  int log_addr [64];
  bit stall_en = 1'b0;
  logic [7:0] lfsr = 8'h5b;
  logic [DW-1:0] cyc = '0;
  int xlat = 0, wcnt = 0, pk = 0;
  bit poke_en = 1'b0;
  logic [DW-1:0] s_ctrl, s_ttnm, s_dptr, s_cmd, s_cmd2, exp_tag;
  bit s_rt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= rst_n ? cyc + 1'b1 : '0;

  always @(negedge clk) begin
    mem_ack   = mem_req && (!stall_en || lfsr[0]);
    mem_rdata = mem[mem_addr];
    lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (nlog < 64) begin
        log_we[nlog]   = mem_we;
        log_addr[nlog] = int'(mem_addr);
      end
      nlog++;
      if (mem_we) mem[mem_addr] <= mem_wdata;
    end
  end

  always @(negedge clk) begin
    if (pk == 1) begin
      start = 1'b0;
      pk = 2;
    end else if (pk == 0 && poke_en && xfer_req) begin
      start = 1'b1;
      start_addr = 8'd128;
      pk = 1;
    end
    if (xfer_done) begin
      xfer_done = 1'b0;
    end else if (xfer_req) begin
      if (wcnt >= xlat) begin
        xfer_done = 1'b1;
        s_ctrl = desc_ctrl; s_ttnm = desc_ttnm; s_dptr = desc_dptr;
        s_cmd = desc_cmd; s_cmd2 = desc_cmd2; s_rt = desc_rtrt;
        exp_tag = cyc;
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic run_msg(input int addr, input bit rt, input int xl, input bit poke);
    int n;
    int ne;
    int eoff [10];
    bit ewe [10];
    bit mis8, mis16, e_err;
    logic [DW-1:0] ev;
    mis8  = (addr % 8) != 0;
    mis16 = !mis8 && rt && (addr % 16) != 0;
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 4951 + addr * 17) ^ 16'h2c5a;
    mem[addr][0] = rt;
    for (int i = 0; i < 256; i++) pre[i] = mem[i];
    xfer_sts = 16'h5100 ^ DW'(addr); xfer_loop = 16'h6200 ^ DW'(addr);
    xfer_bsts = 16'h7300 ^ DW'(addr); xfer_sts2 = 16'h8400 ^ DW'(addr);
    xlat = xl; wcnt = 0; pk = 0; poke_en = poke; nlog = 0;
    @(negedge clk); start = 1'b1; start_addr = AW'(addr);
    @(negedge clk); start = 1'b0; n = 1;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, "R10 done seen", int'(done), 1);
    e_err = mis8 || mis16;
    chk(align_err == e_err, e_err ? "R3/R6 align_err" : "R10 align_err low", int'(align_err), int'(e_err));
    if (mis8) chk(n == 1, "R3 error latency", n, 1);
    ne = 0;
    if (mis16) begin eoff[0] = 0; ewe[0] = 0; ne = 1; end
    else if (!mis8) begin
      for (int k = 0; k < 4; k++) begin eoff[ne] = k; ewe[ne] = 0; ne++; end
      if (rt) begin eoff[ne] = 8; ewe[ne] = 0; ne++; end
      for (int k = 4; k < 8; k++) begin eoff[ne] = k; ewe[ne] = 1; ne++; end
      if (rt) begin eoff[ne] = 9; ewe[ne] = 1; ne++; end
    end
    @(negedge clk);
    chk(!done && !busy, "R10 one-cycle done", int'(done), 0);
    repeat (5) @(negedge clk);
    chk(!busy && !mem_req, "R2 idle after done", int'(busy), 0);
    chk(nlog == ne, mis8 ? "R3 access count" : (mis16 ? "R6 access count" : "R2 access count"), nlog, ne);
    for (int k = 0; k < ne && k < nlog; k++) begin
      chk(log_addr[k] == addr + eoff[k] && log_we[k] == ewe[k],
          ewe[k] ? "R8 write order" : (rt ? "R5 read order" : "R4 read order"),
          log_addr[k] - addr, eoff[k]);
    end
    if (!e_err) begin
      chk(s_ctrl == pre[addr] && s_ttnm == pre[addr+1] && s_dptr == pre[addr+2] && s_cmd == pre[addr+3],
          "R7 descriptor fields", int'(s_cmd), int'(pre[addr+3]));
      chk(s_rt == rt, "R5 desc_rtrt", int'(s_rt), int'(rt));
      if (rt) chk(s_cmd2 == pre[addr+8], "R5 second command", int'(s_cmd2), int'(pre[addr+8]));
    end
    for (int o = 0; o < 16; o++) begin
      ev = pre[addr+o];
      if (!e_err) begin
        if (o == 4) ev = xfer_sts;
        if (o == 5) ev = xfer_loop;
        if (o == 6) ev = xfer_bsts;
        if (o == 7) ev = exp_tag;
        if (o == 9 && rt) ev = xfer_sts2;
      end
      chk(mem[addr+o] == ev, o == 7 && !e_err ? "R9 time tag" : "R8 memory image", int'(mem[addr+o]), int'(ev));
    end
    if (poke) chk(mem[128] == pre[128], "R2 ignored start", int'(mem[128]), int'(pre[128]));
    poke_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !align_err && !mem_req && !xfer_req, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !xfer_req, "R1 idle after release", int'(mem_req), 0);
    for (int s = 0; s < 2; s++) begin
      stall_en = s[0];
      for (int r = 0; r < 2; r++)
        for (int a = 0; a < 48; a++) run_msg(a, r[0], a % 4, 1'b0);
    end
    run_msg(0, 1'b0, 3, 1'b1);
    run_msg(16, 1'b1, 3, 1'b1);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule